// File: doc/BRIEF.md
# Configurable Synchronous Serial Transceiver

This block moves one 8-bit byte at a time over a three-wire synchronous serial link with a select line. As clock master it divides the system clock by one of eight power-of-two ratios and drives the serial clock and the active-low select while the byte is in flight. As clock slave it takes the serial clock and the select from outside, brings both into the system clock domain, and shifts on the edges it detects there.

The clock polarity input sets the level the serial clock rests at. The phase input chooses whether data is launched before the first edge or on it. A separate synchronous-mode input forces the phase behaviour off and leaves polarity in effect. The bit-order input chooses which end of the byte goes first. A one-cycle `start` loads the transmit byte. `busy` covers the transfer, and a one-cycle `done` marks the cycle in which `rx_data` holds the received byte.

Top module: `sync_serial_xcvr`

## Requirements
- R1: During and right after reset, `busy`, `done`, `rx_data` and `sck_o` are 0 and `cs_n_o` is 1.
- R2: In master mode, with rate code k (0 to 7), `sck_o` toggles every 2<<k system clocks, which is a divisor of 4<<k. It makes exactly 16 toggles (8 clock periods) per transfer and holds still between toggles.
- R3: While idle, `sck_o` rests at the level of `cfg_cpol`, and `sck_oe` equals `cfg_master`.
- R4: With phase 0, the first bit is on `sdo` as soon as the transfer begins. Bits are sampled on leading edges (leaving the idle level) and change on trailing edges.
- R5: With phase 1, `sdo` changes on leading edges and bits are sampled on trailing edges.
- R6: When `cfg_sync_mode` is 1, `cfg_cpha` has no effect and the block behaves as with phase 0. Polarity still applies.
- R7: `cfg_msb_first`=0 sends and assembles bit 0 first. A value of 1 sends and assembles bit 7 first.
- R8: In master mode, `cs_n_o` is 0 exactly while `busy` is 1, and it is 1 whenever the block is idle.
- R9: `done` is high for one system clock: in master mode after the 16th clock edge, in slave mode after the 8th sampling edge. In that cycle `busy` is 0 and `rx_data` holds the byte, which is kept until the next completion.
- R10: In slave mode, `sck_i` and `cs_n_i` pass through two flops. Edges count only while a transfer is armed by `start` and the synchronized `cs_n_i` is 0.
- R11: A `start` while `busy` is ignored, and configuration inputs that change while `busy` do not affect the transfer in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1: generate the serial clock; 0: take it from `sck_i` |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_sync_mode | input | 1 | 1: clocked-synchronous mode, phase forced off |
| cfg_msb_first | input | 1 | Bit order select |
| cfg_rate | input | 3 | Master clock rate code |
| start | input | 1 | Load `tx_data` and begin or arm a transfer |
| tx_data | input | 8 | Byte to transmit |
| busy | output | 1 | Transfer in progress or armed |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 8 | Last received byte |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Output enable for `sck_o` |
| sck_i | input | 1 | Serial clock in (slave) |
| cs_n_o | output | 1 | Active-low select out (master) |
| cs_n_i | input | 1 | Active-low select in (slave) |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The properties assume that in slave mode each level of `sck_i` lasts at least two system clocks, which is one quarter of the system clock rate. They also assume that `sdi` is stable around every sampling edge once that edge has crossed the synchronizer. The bench holds each external clock level for six system clocks. It changes `sdi` only at the opposite edge, and it moves `sck_i` and `cs_n_i` in separate cycles. In master mode `sdi` is looped back from `sdo`, so its timing follows the block's own launch edges.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  localparam int SSX_RATE_W = 3;
  localparam int SSX_CNT_W  = (1 << SSX_RATE_W) + 1;

  typedef struct packed {
    logic master;
    logic cpol;
    logic cpha;
    logic sync_mode;
    logic msb_first;
    logic [SSX_RATE_W-1:0] rate;
  } ssx_cfg_t;

  // half period of the master clock in system clocks: divisor (4<<k) / 2
  function automatic int half_period(input logic [SSX_RATE_W-1:0] code);
    return 2 << code;
  endfunction
endpackage

// File: rtl/ssx_prescale.sv
module ssx_prescale
  import ssx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [SSX_RATE_W-1:0] rate,
  output logic                  tick
);
  logic [SSX_CNT_W-1:0] cnt;
  logic [SSX_CNT_W-1:0] limit;

  assign limit = SSX_CNT_W'(half_period(rate) - 1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ssx_sync.sv
module ssx_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic q,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
      s3 <= RST_VAL;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign q    = s2;
  assign rise = s2 && !s3;
  assign fall = !s2 && s3;
endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] tx_data,
  input  logic          lead_ev,
  input  logic          trail_ev,
  input  logic          pha,
  input  logic          msb,
  input  logic          master,
  input  logic          sdi,
  output logic          sdo,
  output logic          sample_ev,
  output logic          finish_ev,
  output logic          done,
  output logic [DW-1:0] rx_data
);
  localparam int EDGES = 2 * DW;
  localparam int IDX_W = $clog2(EDGES);
  localparam logic [IDX_W-1:0] LAST_EDGE = IDX_W'(EDGES - 1);
  localparam logic [IDX_W-1:0] LAST_P0   = IDX_W'(EDGES - 2);

  function automatic logic [DW-1:0] rx_next(input logic [DW-1:0] sr, input logic b,
                                             input logic m);
    return m ? {sr[DW-2:0], b} : {b, sr[DW-1:1]};
  endfunction

  function automatic logic [DW-1:0] tx_next(input logic [DW-1:0] sr, input logic m);
    return m ? {sr[DW-2:0], 1'b0} : {1'b0, sr[DW-1:1]};
  endfunction

  logic [DW-1:0]    tx_sr, rx_sr;
  logic [IDX_W-1:0] idx;
  logic             edge_ev, launch_ev;

  assign edge_ev   = lead_ev || trail_ev;
  assign sample_ev = pha ? trail_ev : lead_ev;
  assign launch_ev = (pha ? lead_ev : trail_ev) && !(pha && idx == '0);
  assign finish_ev = master ? (edge_ev && idx == LAST_EDGE)
                            : (sample_ev && idx == (pha ? LAST_EDGE : LAST_P0));
  assign sdo       = msb ? tx_sr[DW-1] : tx_sr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_sr   <= '0;
      idx     <= '0;
      done    <= 1'b0;
      rx_data <= '0;
    end else begin
      done <= finish_ev;
      if (load) begin
        tx_sr <= tx_data;
        rx_sr <= '0;
        idx   <= '0;
      end else if (edge_ev) begin
        idx <= idx + 1'b1;
        if (launch_ev) tx_sr <= tx_next(tx_sr, msb);
        if (sample_ev) rx_sr <= rx_next(rx_sr, sdi, msb);
      end
      if (finish_ev)
        rx_data <= sample_ev ? rx_next(rx_sr, sdi, msb) : rx_sr;
    end
  end
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_master,
  input  logic                  cfg_cpol,
  input  logic                  cfg_cpha,
  input  logic                  cfg_sync_mode,
  input  logic                  cfg_msb_first,
  input  logic [SSX_RATE_W-1:0] cfg_rate,
  input  logic                  start,
  input  logic [DW-1:0]         tx_data,
  output logic                  busy,
  output logic                  done,
  output logic [DW-1:0]         rx_data,
  output logic                  sck_o,
  output logic                  sck_oe,
  input  logic                  sck_i,
  output logic                  cs_n_o,
  input  logic                  cs_n_i,
  output logic                  sdo,
  input  logic                  sdi
);
  ssx_cfg_t cfg_q;
  logic     sck_q, cs_q;
  logic     load, tick, pha_eff, armed;
  logic     lead_ev, trail_ev, sample_ev, finish_ev;
  logic     s_sck, s_sck_rise, s_sck_fall, s_cs, s_cs_rise, s_cs_fall;

  assign load    = start && !busy;
  assign pha_eff = cfg_q.cpha && !cfg_q.sync_mode;
  assign armed   = busy && !cfg_q.master && !s_cs;

  ssx_prescale u_pre (
    .clk (clk), .rst_n (rst_n), .run (busy && cfg_q.master),
    .rate (cfg_q.rate), .tick (tick)
  );

  ssx_sync #(.RST_VAL(1'b0)) u_sck_sync (
    .clk (clk), .rst_n (rst_n), .async_in (sck_i),
    .q (s_sck), .rise (s_sck_rise), .fall (s_sck_fall)
  );

  ssx_sync #(.RST_VAL(1'b1)) u_cs_sync (
    .clk (clk), .rst_n (rst_n), .async_in (cs_n_i),
    .q (s_cs), .rise (s_cs_rise), .fall (s_cs_fall)
  );

  // leading = leaving the idle level, trailing = returning to it
  always_comb begin
    if (cfg_q.master) begin
      lead_ev  = tick && (sck_q == cfg_q.cpol);
      trail_ev = tick && (sck_q != cfg_q.cpol);
    end else begin
      lead_ev  = armed && (cfg_q.cpol ? s_sck_fall : s_sck_rise);
      trail_ev = armed && (cfg_q.cpol ? s_sck_rise : s_sck_fall);
    end
  end

  ssx_shifter #(.DW(DW)) u_shift (
    .clk (clk), .rst_n (rst_n), .load (load), .tx_data (tx_data),
    .lead_ev (lead_ev), .trail_ev (trail_ev), .pha (pha_eff),
    .msb (cfg_q.msb_first), .master (cfg_q.master), .sdi (sdi),
    .sdo (sdo), .sample_ev (sample_ev), .finish_ev (finish_ev),
    .done (done), .rx_data (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      busy  <= 1'b0;
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      if (!busy) cfg_q <= '{master: cfg_master, cpol: cfg_cpol, cpha: cfg_cpha,
                            sync_mode: cfg_sync_mode, msb_first: cfg_msb_first,
                            rate: cfg_rate};
      if (load)           busy <= 1'b1;
      else if (finish_ev) busy <= 1'b0;
      if (!busy)      sck_q <= cfg_cpol;
      else if (tick)  sck_q <= !sck_q;
      if (load && cfg_master) cs_q <= 1'b0;
      else if (finish_ev)     cs_q <= 1'b1;
    end
  end

  assign sck_o  = sck_q;
  assign sck_oe = cfg_q.master;
  assign cs_n_o = cs_q;
endmodule

// File: rtl/ssx_checker.sv
module ssx_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic cs_n_o,
  input logic sck_o,
  input logic cfg_cpol,
  input logic master_q,
  input logic tick,
  input logic sample_ev,
  input logic finish_ev,
  input logic [7:0] cfg_bits
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_CS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && master_q) |-> !cs_n_o); // R8
  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n_o); // R8
  AST_SCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && master_q && !tick) |=> $stable(sck_o)); // R2
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(!busy)) |-> (sck_o == $past(cfg_cpol))); // R3
  AST_SAMPLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ev |-> busy); // R10
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish_ev) |=> $stable(cfg_bits)); // R11
endmodule

bind sync_serial_xcvr ssx_checker u_chk (
  .clk (clk), .rst_n (rst_n), .busy (busy), .done (done), .cs_n_o (cs_n_o),
  .sck_o (sck_o), .cfg_cpol (cfg_cpol), .master_q (cfg_q.master), .tick (tick),
  .sample_ev (sample_ev), .finish_ev (finish_ev), .cfg_bits (cfg_q)
);

// File: tb/sim_sync_serial_xcvr.sv
module sim_sync_serial_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int SLV_HALF   = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_sync_mode = 1'b0;
  logic cfg_msb_first = 1'b0, start = 1'b0, sck_i = 1'b0, cs_n_i = 1'b1, s_sdi = 1'b0;
  logic [2:0] cfg_rate = 3'd0;
  logic [7:0] tx_data = 8'h00;
  logic busy, done, sck_o, sck_oe, cs_n_o, sdo, sdi;
  logic [7:0] rx_data;

  // bench-side picture of the transfer in flight
  logic m_master = 1'b1, m_cpol = 1'b0, m_pha = 1'b0, m_msb = 1'b0;
  int   m_half = 2;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] tx;
    logic [7:0] rx;
    string      tag;
  } item_t;
  item_t sbq[$];

  assign sdi = m_master ? sdo : s_sdi;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_serial_xcvr u0 (
    .clk (clk), .rst_n (rst_n), .cfg_master (cfg_master), .cfg_cpol (cfg_cpol),
    .cfg_cpha (cfg_cpha), .cfg_sync_mode (cfg_sync_mode), .cfg_msb_first (cfg_msb_first),
    .cfg_rate (cfg_rate), .start (start), .tx_data (tx_data), .busy (busy),
    .done (done), .rx_data (rx_data), .sck_o (sck_o), .sck_oe (sck_oe),
    .sck_i (sck_i), .cs_n_o (cs_n_o), .cs_n_i (cs_n_i), .sdo (sdo), .sdi (sdi)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // monitor: captures sdo at sampling edges, measures the clock, pops on done
  logic [7:0] obs = 8'h00;
  int nb = 0, nedge = 0, gap = 0, per_bad = 0, cs_bad = 0;
  logic psck = 1'b0, pcs = 1'b1;
  always @(negedge clk) begin
    logic lsck, lcs, lead;
    item_t it;
    lsck = m_master ? sck_o : sck_i;
    lcs  = m_master ? cs_n_o : cs_n_i;
    if (rst_n) begin
      gap++;
      if (!pcs && lsck != psck) begin
        lead = (lsck != m_cpol);
        if (m_pha ? !lead : lead) begin
          obs = m_msb ? {obs[6:0], sdo} : {sdo, obs[7:1]};
          nb++;
        end
        if (m_master) begin
          if (nedge > 0 && gap != m_half) per_bad++;
          nedge++;
        end
        gap = 0;
      end
      if (m_master && busy && cs_n_o) cs_bad++;
      if (done) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R11 unexpected done", 1, 0);
        end else begin
          it = sbq.pop_front();
          check(rx_data == it.rx, "R9/R7 rx_data", rx_data, it.rx);
          check(obs == it.tx && nb == 8, it.tag, obs, it.tx);
          check(!busy, "R9 busy low with done", busy, 0);
          if (m_master) begin
            check(nedge == 16 && per_bad == 0, "R2 clock edges/half period", nedge, 16);
            check(cs_bad == 0, "R8 cs_n_o during transfer", cs_bad, 0);
          end
        end
        obs = 8'h00; nb = 0; nedge = 0; per_bad = 0; cs_bad = 0;
      end
    end
    psck = lsck;
    pcs  = lcs;
  end

  task automatic master_xfer(input logic [7:0] b, input logic [2:0] rate, input logic pol,
                             input logic ph, input logic sm, input logic msb, input string tag);
    item_t it;
    cfg_master = 1'b1; cfg_rate = rate; cfg_cpol = pol; cfg_cpha = ph;
    cfg_sync_mode = sm; cfg_msb_first = msb;
    m_master = 1'b1; m_cpol = pol; m_pha = ph && !sm; m_msb = msb; m_half = 2 << rate;
    step(2);
    it.tx = b; it.rx = b; it.tag = tag;
    sbq.push_back(it);
    tx_data = b; start = 1'b1;
    step(1);
    start = 1'b0;
    do step(1); while (busy);
    step(2);
  endtask

  task automatic slave_xfer(input logic [7:0] b, input logic [7:0] line_in, input logic pol,
                            input logic ph, input logic sm, input logic msb, input string tag);
    item_t it;
    logic pe;
    pe = ph && !sm;
    cfg_master = 1'b0; cfg_cpol = pol; cfg_cpha = ph; cfg_sync_mode = sm; cfg_msb_first = msb;
    m_master = 1'b0; m_cpol = pol; m_pha = pe; m_msb = msb;
    sck_i = pol;
    step(4);
    it.tx = b; it.rx = line_in; it.tag = tag;
    sbq.push_back(it);
    tx_data = b; start = 1'b1;
    step(1);
    start = 1'b0;
    step(3);
    cs_n_i = 1'b0;
    if (!pe) s_sdi = msb ? line_in[7] : line_in[0];
    step(SLV_HALF);
    for (int i = 0; i < 8; i++) begin
      sck_i = !pol;
      if (pe) s_sdi = msb ? line_in[7-i] : line_in[i];
      step(SLV_HALF);
      sck_i = pol;
      step(1);
      if (!pe && i < 7) s_sdi = msb ? line_in[6-i] : line_in[i+1];
      step(SLV_HALF - 1);
    end
    step(4);
    cs_n_i = 1'b1;
    step(4);
    check(!busy, "R10 slave transfer finished", busy, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    item_t it;
    step(3);
    check(busy == 0 && done == 0, "R1 busy/done in reset", {busy, done}, 0);
    check(cs_n_o == 1 && sck_o == 0, "R1 cs/sck in reset", {cs_n_o, sck_o}, 2);
    check(rx_data == 8'h00, "R1 rx_data in reset", rx_data, 0);
    rst_n = 1'b1;
    step(1);
    check(busy == 0 && cs_n_o == 1 && done == 0, "R1 after reset", {busy, cs_n_o, done}, 2);

    // master, various patterns
    master_xfer(8'hB4, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 R7 master lsb ph0");
    master_xfer(8'h3C, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1, "R5 R7 master msb ph1");
    master_xfer(8'h81, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0, "R6 sync mode ignores phase");
    master_xfer(8'h5A, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, "R6 sync mode keeps polarity");
    master_xfer(8'hE7, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, "R2 slowest rate");

    // R3 idle level and output enable
    cfg_cpol = 1'b1;
    step(2);
    check(sck_o == 1 && sck_oe == 1, "R3 idle level high", {sck_o, sck_oe}, 3);
    cfg_cpol = 1'b0;
    step(2);
    check(sck_o == 0, "R3 idle level low", sck_o, 0);

    // R11: second start and config change while busy are ignored
    cfg_master = 1'b1; cfg_rate = 3'd1; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    cfg_sync_mode = 1'b0; cfg_msb_first = 1'b0;
    m_master = 1'b1; m_cpol = 1'b0; m_pha = 1'b0; m_msb = 1'b0; m_half = 4;
    step(2);
    it.tx = 8'h96; it.rx = 8'h96; it.tag = "R11 start while busy ignored";
    sbq.push_back(it);
    tx_data = 8'h96; start = 1'b1;
    step(1);
    start = 1'b0;
    step(10);
    tx_data = 8'h0F; start = 1'b1; cfg_msb_first = 1'b1; cfg_cpha = 1'b1; cfg_rate = 3'd0;
    step(1);
    start = 1'b0;
    do step(1); while (busy);
    step(4);
    check(sbq.size() == 0 && !busy, "R11 single completion", sbq.size(), 0);
    cfg_msb_first = 1'b0; cfg_cpha = 1'b0;

    // slave mode
    cfg_master = 1'b0;
    step(2);
    check(sck_oe == 0, "R3 output enable off in slave", sck_oe, 0);
    slave_xfer(8'hC3, 8'h5E, 1'b0, 1'b0, 1'b0, 1'b0, "R10 R4 slave ph0 lsb");
    slave_xfer(8'h1D, 8'hA7, 1'b1, 1'b1, 1'b0, 1'b1, "R10 R5 slave ph1 msb");
    slave_xfer(8'h6B, 8'h92, 1'b1, 1'b1, 1'b1, 1'b0, "R10 R6 slave sync mode");

    // R10: clock edges with no transfer armed are ignored
    sck_i = 1'b0; step(3);
    cs_n_i = 1'b0; step(3);
    for (int i = 0; i < 4; i++) begin
      sck_i = 1'b1; step(SLV_HALF);
      sck_i = 1'b0; step(SLV_HALF);
    end
    cs_n_i = 1'b1; step(4);
    check(!busy && rx_data == 8'h92, "R10 unarmed edges ignored", rx_data, 8'h92);

    step(4);
    check(sbq.size() == 0, "R9 all transfers completed", sbq.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule